// File: doc/BRIEF.md
# Cascadable Multichannel Output Summer

This block adds four per-channel sample streams and the word arriving on a cascade bus from an upstream device in a chain. It formats the total as one 18-bit parallel output word. Several devices can be chained: each device sends its output bus to the cascade input of the next one, so the last device in the chain carries the sum of every channel. The cascade term can be masked so that the block ignores its upstream neighbour.

The channels present their samples together and mark them with a single valid strobe. In complex operation, I and Q words take turns on the same bus. A tag marks the Q word, and the block passes that tag on at its output. The raw sum is kept in a wider accumulator. It is then shifted right by 0 to 3 places, clipped or wrapped into 18 bits, and coded as either two's complement or offset binary. The result is registered. An output-enable input gates the bus. It also drives a direction-select output that a pad ring would use.

Top module: `casc_sum`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid strobe, the registered word is zero and `out_q` is 0. With `out_en` high, `out_bus` then reads 0.
- R2: One clock edge after `in_vld` is high, the registered word equals the signed sum of the four 18-bit channel samples (channel k in `ch_data[18k+17:18k]`) plus the signed cascade word. The sum is formed in a 21-bit accumulator.
- R3: With `casc_mask` high, the cascade word adds nothing to the sum.
- R4: The accumulator is arithmetically shifted right by `cfg_shift` places (0 to 3) before range handling. The shift rounds toward minus infinity.
- R5: With `cfg_wrap` low, a shifted value above 131071 gives 131071, and a value below -131072 gives -131072.
- R6: With `cfg_wrap` high, an out-of-range value keeps only its low 18 bits.
- R7: With `cfg_offbin` high, bit 17 of the stored word is inverted (offset binary). With `cfg_offbin` low, the word is two's complement.
- R8: In complex mode (`cfg_complex` high), `out_q` takes the value of `in_is_q` one edge after a valid strobe (1 = Q word). In real mode, `out_q` goes to 0.
- R9: In complex mode, the cascade word contributes only when `casc_q` equals `in_is_q`. In real mode, `casc_q` is ignored.
- R10: While `in_vld` is low, `out_bus` and `out_q` hold their values, whatever the other inputs do.
- R11: `out_drive` follows `out_en` without delay. While `out_en` is low, `out_bus` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Channel samples valid this cycle |
| in_is_q | input | 1 | The current channel word set is Q (complex mode) |
| ch_data | input | 72 | Four signed 18-bit channel samples, channel 0 in the low bits |
| casc_in | input | 18 | Signed word from the upstream device |
| casc_q | input | 1 | The upstream word is Q |
| casc_mask | input | 1 | Ignore the upstream word |
| cfg_complex | input | 1 | 1 = interleaved complex, 0 = real |
| cfg_shift | input | 2 | Right shift applied to the sum |
| cfg_wrap | input | 1 | 1 = wrap on overflow, 0 = clip |
| cfg_offbin | input | 1 | 1 = offset binary output |
| out_en | input | 1 | Output enable |
| out_bus | output | 18 | Formatted output word |
| out_q | output | 1 | Output word is Q |
| out_drive | output | 1 | Pad direction select (1 = drive) |

## Verification
The bench aims at the range limits. It sums values just past ±131072 under clipping and under wrapping. A design that drops the accumulator guard bits, or that clips in the wrong direction, gives a wrapped sign or a value stuck at the wrong rail. The bench checks negative sums with odd shifts. A logical shift instead of an arithmetic one would give a large positive word. It drives the cascade with a mismatched Q tag, with the mask set, and with valid low. A design that adds a stale or masked upstream word, or that updates without a strobe, shows a shifted sum on the bus. Offset binary is compared at both rails, so an inversion of the wrong bit is exposed.

// File: rtl/casc_sum.sv
module casc_sum #(
  parameter int NCH = 4,
  parameter int SW  = 18,
  parameter int OW  = 18,
  parameter int SHW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_is_q,
  input  logic [NCH*SW-1:0] ch_data,
  input  logic [OW-1:0]     casc_in,
  input  logic              casc_q,
  input  logic              casc_mask,
  input  logic              cfg_complex,
  input  logic [SHW-1:0]    cfg_shift,
  input  logic              cfg_wrap,
  input  logic              cfg_offbin,
  input  logic              out_en,
  output logic [OW-1:0]     out_bus,
  output logic              out_q,
  output logic              out_drive
);
  localparam int XW = (SW > OW) ? SW : OW;
  localparam int AW = XW + $clog2(NCH + 1);
  localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic              casc_use;
  logic signed [AW-1:0] acc, scaled;
  logic [OW-1:0]     ranged, fmt, res_q;
  logic              too_hi, too_lo;

  assign casc_use = !casc_mask && (!cfg_complex || (casc_q == in_is_q));

  always_comb begin
    acc = casc_use ? {{(AW-OW){casc_in[OW-1]}}, casc_in} : '0;
    for (int k = 0; k < NCH; k++)
      acc = acc + {{(AW-SW){ch_data[k*SW+SW-1]}}, ch_data[k*SW +: SW]};
  end

  assign scaled = acc >>> cfg_shift;
  assign too_hi = scaled > MAXV;
  assign too_lo = scaled < MINV;

  always_comb begin
    if (too_hi && !cfg_wrap)      ranged = MAXV[OW-1:0];
    else if (too_lo && !cfg_wrap) ranged = MINV[OW-1:0];
    else                          ranged = scaled[OW-1:0];
  end

  assign fmt = ranged ^ {cfg_offbin, {(OW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      out_q <= 1'b0;
    end else if (in_vld) begin
      res_q <= fmt;
      out_q <= cfg_complex && in_is_q;
    end
  end

  assign out_bus   = out_en ? res_q : '0;
  assign out_drive = out_en;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(res_q) && $stable(out_q)));

  assert_real_noq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !cfg_complex) |=> !out_q);

  assert_cplx_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && cfg_complex) |=> (out_q == $past(in_is_q)));

  assert_clip_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !cfg_wrap && !cfg_offbin && too_hi) |=> (res_q == MAXV[OW-1:0]));

  assert_clip_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !cfg_wrap && !cfg_offbin && too_lo) |=> (res_q == MINV[OW-1:0]));

  assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (out_bus == '0 && !out_drive));
endmodule

// File: tb/sim_casc_sum.sv
module sim_casc_sum;
  logic clk = 0, rst_n = 0;
  logic in_vld = 0, in_is_q = 0, casc_q = 0, casc_mask = 0;
  logic cfg_complex = 0, cfg_wrap = 0, cfg_offbin = 0, out_en = 1;
  logic [71:0] ch_data = '0;
  logic [17:0] casc_in = '0;
  logic [1:0]  cfg_shift = '0;
  logic [17:0] out_bus;
  logic        out_q, out_drive;
  int n_chk = 0, n_bad = 0;
  logic [17:0] last_w = '0;
  logic        last_q = 0;

  always #5 clk = ~clk;

  casc_sum u0 (.clk, .rst_n, .in_vld, .in_is_q, .ch_data, .casc_in, .casc_q,
    .casc_mask, .cfg_complex, .cfg_shift, .cfg_wrap, .cfg_offbin, .out_en,
    .out_bus, .out_q, .out_drive);

  function automatic logic [17:0] model();
    longint s = 0;
    logic [17:0] r;
    for (int k = 0; k < 4; k++) s += longint'($signed(ch_data[k*18 +: 18]));
    if (!casc_mask && (!cfg_complex || casc_q == in_is_q)) s += longint'($signed(casc_in));
    s = s >>> cfg_shift;
    if (s > 131071)       r = cfg_wrap ? s[17:0] : 18'h1ffff;
    else if (s < -131072) r = cfg_wrap ? s[17:0] : 18'h20000;
    else                  r = s[17:0];
    r[17] = r[17] ^ cfg_offbin;
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [17:0] ew;
    logic        eq;
    ew = in_vld ? model() : last_w;
    eq = in_vld ? (cfg_complex && in_is_q) : last_q;
    @(posedge clk); #2;
    last_w = ew; last_q = eq;
    check(out_bus == (out_en ? ew : 18'h0), tag, out_bus, out_en ? ew : 18'h0);
    check(out_q == eq, {tag, " qflag R8"}, out_q, eq);
    check(out_drive == out_en, {tag, " drive R11"}, out_drive, out_en);
    @(negedge clk);
  endtask

  function automatic logic [71:0] pack(input int a, input int b, input int c, input int d);
    return {18'(d), 18'(c), 18'(b), 18'(a)};
  endfunction

  task automatic setcfg(input logic cx, input logic [1:0] sh, input logic wr, input logic ob);
    cfg_complex = cx; cfg_shift = sh; cfg_wrap = wr; cfg_offbin = ob;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4821));
    repeat (3) @(negedge clk);
    check(out_bus == 0 && out_q == 0, "R1 in reset", out_bus, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_bus == 0 && out_q == 0, "R1 after release", out_bus, 0);

    in_vld = 1;
    ch_data = pack(100, -20, 3000, 7); casc_in = 18'(-50); step("R2 plain sum");
    casc_mask = 1; casc_in = 18'd5000; step("R3 cascade masked");
    casc_mask = 0;
    setcfg(0, 2'd1, 0, 0); ch_data = pack(-3, 0, 0, 0); casc_in = 0; step("R4 shift floor -3>>1");
    setcfg(0, 2'd3, 0, 0); ch_data = pack(-131072, -131072, -131072, -131072); casc_in = 18'h20000; step("R4 shift 3 neg");
    setcfg(0, 2'd0, 0, 0); ch_data = pack(131071, 1, 0, 0); casc_in = 0; step("R5 clip high");
    ch_data = pack(-131072, -1, 0, 0); step("R5 clip low");
    setcfg(0, 2'd0, 1, 0); ch_data = pack(131071, 1, 0, 0); step("R6 wrap high");
    ch_data = pack(-131072, -131072, -131072, 5); step("R6 wrap low");
    setcfg(0, 2'd0, 0, 1); ch_data = pack(131071, 131071, 0, 0); step("R7 offbin top rail");
    ch_data = pack(-131072, -9, 0, 0); step("R7 offbin bottom rail");
    ch_data = pack(0, 0, 0, 0); step("R7 offbin zero");
    setcfg(1, 2'd0, 0, 0); in_is_q = 1; casc_q = 1; ch_data = pack(10, 20, 30, 40); casc_in = 18'd1000; step("R8 R9 Q matched");
    in_is_q = 0; casc_q = 1; step("R9 tag mismatch ignored");
    setcfg(0, 2'd0, 0, 0); in_is_q = 1; casc_q = 0; step("R8 R9 real mode");
    in_vld = 0; ch_data = pack(9999, 1, 2, 3); casc_in = 18'd77; cfg_complex = 1; in_is_q = 1; step("R10 hold");
    out_en = 0; in_vld = 1; step("R11 gated");
    out_en = 1; in_vld = 0; step("R11 reenabled");

    for (int i = 0; i < 400; i++) begin
      in_vld = ($urandom % 4) != 0;
      in_is_q = $urandom; casc_q = $urandom; casc_mask = ($urandom % 4) == 0;
      setcfg($urandom, 2'($urandom), $urandom, $urandom);
      out_en = ($urandom % 8) != 0;
      if ($urandom % 2) ch_data = {$urandom, $urandom, $urandom};
      else ch_data = pack($signed($urandom % 2001) - 1000, $signed($urandom % 2001) - 1000,
                          $signed($urandom % 2001) - 1000, $signed($urandom % 2001) - 1000);
      casc_in = 18'($urandom);
      step("R2 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule